// File: doc/BRIEF.md
# Audio bit clock and word strobe generator

This block produces the serial bit clock and the word strobe for an audio output serializer. The oversampling master clock enters as a single-cycle enable (`mclk_en_i`), one pulse per master period. A first divider turns master ticks into bit-clock periods. A second divider, stepped by bit-clock rising edges, turns bit periods into serial frames. One frame is one word strobe period, and it carries one sample per active channel, so the strobe period sets the sample rate.

A role select picks who owns the timing. In master role the block drives both pins and asserts their output enables. In slave role the pins are inputs from an external converter. The block brings them into the core clock domain and detects their edges. In both roles the serializer uses the same one-cycle indications: bit-clock rise, bit-clock fall and frame start. The role is captured only while transmit is disabled. Divider values written during a run wait for the next frame boundary.

Top module: `audio_clk_gen`

## Requirements
- R1: After reset the role is slave (`sck_oe_o` = `ws_oe_o` = 0) and `sck_o`, `ws_o`, `sck_rise_o`, `sck_fall_o` and `frame_o` are all 0.
- R2: `master_sel_i` (1 = master, 0 = slave) is captured on each clock edge while `tx_en_i` is 0 and is ignored while `tx_en_i` is 1. Both output enables equal the captured role.
- R3: In master role, with N = `sck_div_i` + 1, the bit clock period is N master ticks. It is high for the first (N+1)/2 ticks (integer division) and low for the rest. `sck_rise_o` pulses with the tick that starts the high phase and `sck_fall_o` with the tick that starts the low phase, in the same cycle as the level change. For N = 1 the level stays high and both indications pulse on every tick.
- R4: In master role, with F = `ws_div_i` + 1, a frame is F bit periods counted from bit-clock rises. `ws_o` is high during bits 0 to (F+1)/2 - 1 of each frame and low otherwise. `frame_o` pulses together with `sck_rise_o` at bit 0.
- R5: The first master tick after `tx_en_i` rises starts bit 0 of a new frame, with `sck_rise_o` and `frame_o` pulsing.
- R6: Master outputs change only in the cycle after a clock edge that saw `mclk_en_i` = 1. In all other cycles the three indications are 0 and the levels hold.
- R7: A divider value changed while running takes effect at the first frame boundary tick at or after the change, and every frame before it completes with the old values.
- R8: While `tx_en_i` is 0, `sck_o` and `ws_o` are 0 in the same cycle, the indications are 0 from the next cycle, and `mclk_en_i` has no effect. A restart begins fresh per R5.
- R9: In slave role, `sck_o` and `ws_o` are 0 and `mclk_en_i` has no effect. Each edge of `sck_pad_i` yields exactly one `sck_rise_o` or `sck_fall_o` pulse, visible SYNC_STAGES + 1 clock edges after the pad change.
- R10: In slave role, `frame_o` pulses with a bit-clock rise at which the synchronized `ws_pad_i` is 1 and was 0 at the previous rise. The first rise after enabling counts the previous value as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mclk_en_i | input | 1 | One-cycle tick per oversampling master clock period |
| tx_en_i | input | 1 | Transmit enable |
| master_sel_i | input | 1 | Requested role, 1 = master, captured only while disabled |
| sck_div_i | input | SCK_DIV_W (8) | Bit clock ratio minus one |
| ws_div_i | input | WS_DIV_W (9) | Frame length in bits minus one |
| sck_pad_i | input | 1 | Bit clock from the external converter (slave role) |
| ws_pad_i | input | 1 | Word strobe from the external converter (slave role) |
| sck_o | output | 1 | Generated bit clock |
| sck_oe_o | output | 1 | Bit clock pad output enable |
| ws_o | output | 1 | Generated word strobe |
| ws_oe_o | output | 1 | Word strobe pad output enable |
| sck_rise_o | output | 1 | Bit clock rising-edge indication |
| sck_fall_o | output | 1 | Bit clock falling-edge indication |
| frame_o | output | 1 | Frame start indication |

## Verification
A phase counter that is off by one shows up on the first master tick after enabling. The rise, fall and level pattern then leaves the (N+1)/2 split, and `frame_o` no longer lands on every N·F-th tick. A bad frame count shows within one frame as a misplaced strobe edge. A stale or early divider capture shifts the first frame after a change by a whole bit or frame. A role register that follows the select during a run flips the output enables within one cycle. A synchronizer fault in slave role appears as a missing or doubled indication, or a latency other than SYNC_STAGES + 1 edges, on the first pad edge.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
  typedef enum logic {
    ROLE_SLAVE  = 1'b0,
    ROLE_MASTER = 1'b1
  } role_e;

  typedef struct packed {
    logic rise;
    logic fall;
    logic frame;
  } sck_evt_t;
endpackage

// File: rtl/aclk_bit_div.sv
module aclk_bit_div #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic [W-1:0] ratio_m1_i,
  output logic         sck_o,
  output logic         rise_o,
  output logic         fall_o,
  output logic         rise_evt_o
);
  localparam int unsigned HW = W + 1;

  logic         started_q;
  logic [W-1:0] ph_q, ph_d;
  logic [HW-1:0] hi_len;
  logic         single, lvl_d, fall_d;

  // high phase = ceil(ratio / 2)
  assign hi_len = ({1'b0, ratio_m1_i} + HW'(2)) >> 1;
  assign single = (ratio_m1_i == '0);

  always_comb begin
    if (!started_q || ph_q == ratio_m1_i) ph_d = '0;
    else                                  ph_d = ph_q + 1'b1;
    lvl_d  = {1'b0, ph_d} < hi_len;
    fall_d = single || ({1'b0, ph_d} == hi_len);
  end

  assign rise_evt_o = run_i & tick_i & (ph_d == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      ph_q      <= '0;
      sck_o     <= 1'b0;
      rise_o    <= 1'b0;
      fall_o    <= 1'b0;
    end else if (!run_i) begin
      started_q <= 1'b0;
      ph_q      <= '0;
      sck_o     <= 1'b0;
      rise_o    <= 1'b0;
      fall_o    <= 1'b0;
    end else if (tick_i) begin
      started_q <= 1'b1;
      ph_q      <= ph_d;
      sck_o     <= lvl_d;
      rise_o    <= (ph_d == '0);
      fall_o    <= fall_d;
    end else begin
      rise_o    <= 1'b0;
      fall_o    <= 1'b0;
    end
  end
endmodule

// File: rtl/aclk_frame_cnt.sv
module aclk_frame_cnt #(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         rise_evt_i,
  input  logic [W-1:0] len_m1_i,
  output logic         ws_o,
  output logic         frame_o,
  output logic         bound_o
);
  localparam int unsigned HW = W + 1;

  logic          started_q;
  logic [W-1:0]  bi_q, bi_d;
  logic [HW-1:0] hi_len;

  assign hi_len = ({1'b0, len_m1_i} + HW'(2)) >> 1;

  always_comb begin
    if (!started_q || bi_q == len_m1_i) bi_d = '0;
    else                                bi_d = bi_q + 1'b1;
  end

  // frame boundary tick: load point for new divider values
  assign bound_o = rise_evt_i & (bi_d == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      bi_q      <= '0;
      ws_o      <= 1'b0;
      frame_o   <= 1'b0;
    end else if (!run_i) begin
      started_q <= 1'b0;
      bi_q      <= '0;
      ws_o      <= 1'b0;
      frame_o   <= 1'b0;
    end else if (rise_evt_i) begin
      started_q <= 1'b1;
      bi_q      <= bi_d;
      ws_o      <= {1'b0, bi_d} < hi_len;
      frame_o   <= (bi_d == '0);
    end else begin
      frame_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/aclk_slave_edge.sv
module aclk_slave_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic sck_pad_i,
  input  logic ws_pad_i,
  output logic rise_o,
  output logic fall_o,
  output logic frame_o
);
  logic [STAGES-1:0] sck_sync_q, ws_sync_q;
  logic sck_prev_q, ws_last_q;
  logic sck_s, ws_s, rise_e, fall_e;

  assign sck_s  = sck_sync_q[STAGES-1];
  assign ws_s   = ws_sync_q[STAGES-1];
  assign rise_e = sck_s & ~sck_prev_q;
  assign fall_e = ~sck_s & sck_prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sck_sync_q <= '0;
          ws_sync_q  <= '0;
        end else begin
          sck_sync_q <= sck_pad_i;
          ws_sync_q  <= ws_pad_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sck_sync_q <= '0;
          ws_sync_q  <= '0;
        end else begin
          sck_sync_q <= {sck_sync_q[STAGES-2:0], sck_pad_i};
          ws_sync_q  <= {ws_sync_q[STAGES-2:0], ws_pad_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_prev_q <= 1'b0;
      ws_last_q  <= 1'b0;
      rise_o     <= 1'b0;
      fall_o     <= 1'b0;
      frame_o    <= 1'b0;
    end else begin
      sck_prev_q <= sck_s;
      if (!run_i) begin
        ws_last_q <= 1'b0;
        rise_o    <= 1'b0;
        fall_o    <= 1'b0;
        frame_o   <= 1'b0;
      end else begin
        rise_o  <= rise_e;
        fall_o  <= fall_e;
        frame_o <= rise_e & ws_s & ~ws_last_q;
        if (rise_e) ws_last_q <= ws_s;
      end
    end
  end
endmodule

// File: rtl/audio_clk_gen.sv
module audio_clk_gen
  import aclk_pkg::*;
#(
  parameter int unsigned SCK_DIV_W   = 8,
  parameter int unsigned WS_DIV_W    = 9,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mclk_en_i,
  input  logic                 tx_en_i,
  input  logic                 master_sel_i,
  input  logic [SCK_DIV_W-1:0] sck_div_i,
  input  logic [WS_DIV_W-1:0]  ws_div_i,
  input  logic                 sck_pad_i,
  input  logic                 ws_pad_i,
  output logic                 sck_o,
  output logic                 sck_oe_o,
  output logic                 ws_o,
  output logic                 ws_oe_o,
  output logic                 sck_rise_o,
  output logic                 sck_fall_o,
  output logic                 frame_o
);
  role_e                role_q;
  logic [SCK_DIV_W-1:0] act_sck_q;
  logic [WS_DIV_W-1:0]  act_ws_q;
  logic                 is_master, run_m, run_s, tick;
  logic                 m_sck, m_ws, rise_evt, bound;
  sck_evt_t             m_evt, s_evt, evt;

  assign is_master = (role_q == ROLE_MASTER);
  assign run_m     = tx_en_i & is_master;
  assign run_s     = tx_en_i & ~is_master;
  assign tick      = mclk_en_i & is_master;

  // role accepted only while disabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       role_q <= ROLE_SLAVE;
    else if (!tx_en_i) role_q <= role_e'(master_sel_i);
  end

  // divider shadow: tracks inputs while idle, reloads at frame boundaries
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_sck_q <= '0;
      act_ws_q  <= '0;
    end else if (!tx_en_i || bound) begin
      act_sck_q <= sck_div_i;
      act_ws_q  <= ws_div_i;
    end
  end

  aclk_bit_div #(.W(SCK_DIV_W)) i_bit_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_m),
    .tick_i     (tick),
    .ratio_m1_i (act_sck_q),
    .sck_o      (m_sck),
    .rise_o     (m_evt.rise),
    .fall_o     (m_evt.fall),
    .rise_evt_o (rise_evt)
  );

  aclk_frame_cnt #(.W(WS_DIV_W)) i_frame_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_m),
    .rise_evt_i (rise_evt),
    .len_m1_i   (act_ws_q),
    .ws_o       (m_ws),
    .frame_o    (m_evt.frame),
    .bound_o    (bound)
  );

  aclk_slave_edge #(.STAGES(SYNC_STAGES)) i_slave_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_s),
    .sck_pad_i (sck_pad_i),
    .ws_pad_i  (ws_pad_i),
    .rise_o    (s_evt.rise),
    .fall_o    (s_evt.fall),
    .frame_o   (s_evt.frame)
  );

  assign evt = is_master ? m_evt : s_evt;

  assign sck_o      = run_m & m_sck;
  assign ws_o       = run_m & m_ws;
  assign sck_oe_o   = is_master;
  assign ws_oe_o    = is_master;
  assign sck_rise_o = evt.rise;
  assign sck_fall_o = evt.fall;
  assign frame_o    = evt.frame;
endmodule

// File: rtl/audio_clk_gen_chk.sv
module audio_clk_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic mclk_en_i,
  input logic tx_en_i,
  input logic sck_o,
  input logic sck_oe_o,
  input logic ws_o,
  input logic ws_oe_o,
  input logic sck_rise_o,
  input logic sck_fall_o,
  input logic frame_o
);
  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> (!sck_rise_o && !sck_fall_o && !frame_o));

  p_idle_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |-> (!sck_o && !ws_o));

  p_role_locked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_i |=> ($stable(sck_oe_o) && $stable(ws_oe_o)));

  p_rise_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_rise_o && sck_oe_o && tx_en_i) |-> sck_o);

  p_fall_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_fall_o && !sck_rise_o && sck_oe_o && tx_en_i) |-> !sck_o);

  p_frame_on_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> sck_rise_o);

  p_frame_ws_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_o && sck_oe_o && tx_en_i) |-> ws_o);

  p_no_tick_no_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mclk_en_i && sck_oe_o) |=> (!sck_rise_o && !sck_fall_o && !frame_o));

  p_slave_pads_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sck_oe_o |-> (!sck_o && !ws_o && !ws_oe_o));
endmodule

bind audio_clk_gen audio_clk_gen_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mclk_en_i  (mclk_en_i),
  .tx_en_i    (tx_en_i),
  .sck_o      (sck_o),
  .sck_oe_o   (sck_oe_o),
  .ws_o       (ws_o),
  .ws_oe_o    (ws_oe_o),
  .sck_rise_o (sck_rise_o),
  .sck_fall_o (sck_fall_o),
  .frame_o    (frame_o)
);

// File: tb/test_audio_clk_gen.sv
module test_audio_clk_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mclk_en = 1'b0, tx_en = 1'b0, master_sel = 1'b0;
  logic [7:0] sck_div = '0;
  logic [8:0] ws_div = '0;
  logic       sck_pad = 1'b0, ws_pad = 1'b0;
  logic       sck, sck_oe, ws, ws_oe, rise, fall, frame;
  int         n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  audio_clk_gen i_audio_clk_gen (
    .clk_i(clk), .rst_ni(rst_n), .mclk_en_i(mclk_en), .tx_en_i(tx_en),
    .master_sel_i(master_sel), .sck_div_i(sck_div), .ws_div_i(ws_div),
    .sck_pad_i(sck_pad), .ws_pad_i(ws_pad), .sck_o(sck), .sck_oe_o(sck_oe),
    .ws_o(ws), .ws_oe_o(ws_oe), .sck_rise_o(rise), .sck_fall_o(fall), .frame_o(frame)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int outs();
    return {27'd0, sck, ws, rise, fall, frame};
  endfunction

  // expected {sck, ws, rise, fall, frame} for tick j of a run with ratio n and frame f
  function automatic int expect_at(input int jj, input int n, input int f);
    int ph, bi, hi, fh;
    bit e_r;
    ph  = jj % n;
    bi  = (jj / n) % f;
    hi  = (n + 1) / 2;
    fh  = (f + 1) / 2;
    e_r = (ph == 0);
    return {27'd0, ph < hi, bi < fh, e_r, (n == 1) || (ph == hi), e_r && bi == 0};
  endfunction

  task automatic run_master(input int n, input int f, input int period, input int len,
                            input int chg_at, input int n2, input int f2, input string req);
    int  j, j0, p1, errs, first_act, first_exp, exp_v;
    bit  fired;
    logic last_sck, last_ws;
    @(negedge clk);
    tx_en = 0; master_sel = 1; mclk_en = 0;
    sck_div = 8'(n - 1); ws_div = 9'(f - 1);
    @(negedge clk);
    @(negedge clk);
    tx_en = 1;
    j = 0; j0 = -1; p1 = n * f; errs = 0; first_act = 0; first_exp = 0;
    last_sck = 0; last_ws = 0;
    for (int c = 0; c < len * period; c++) begin
      mclk_en = (c % period == 0);
      fired = mclk_en;
      @(negedge clk);
      if (fired) begin
        if (j0 >= 0 && j >= j0) exp_v = expect_at(j - j0, n2, f2);
        else                    exp_v = expect_at(j, n, f);
        if (outs() != exp_v || sck_oe !== 1'b1) begin
          if (errs == 0) begin first_act = outs(); first_exp = exp_v; end
          errs++;
        end
        if (j == chg_at) begin
          sck_div = 8'(n2 - 1); ws_div = 9'(f2 - 1);
          j0 = ((j + 1 + p1 - 1) / p1) * p1;
        end
        j++;
      end else begin
        if (rise || fall || frame || sck !== last_sck || ws !== last_ws) begin
          if (errs == 0) begin first_act = outs(); first_exp = {27'd0, last_sck, last_ws, 3'b000}; end
          errs++;
        end
      end
      last_sck = sck; last_ws = ws;
    end
    check(errs == 0, req, $sformatf("pattern n=%0d f=%0d period=%0d", n, f, period),
          first_act, first_exp);
    // disable with ticks still arriving
    tx_en = 0; mclk_en = 1;
    #1;
    check(!sck && !ws, "R8", "levels low while disabled", {sck, ws}, 0);
    @(negedge clk);
    check(outs() == 0, "R8", "outputs after disable", outs(), 0);
    mclk_en = 0;
  endtask

  task automatic run_slave();
    int n_r, n_f, n_fr, first_r, cyc;
    bit bad_pad;
    @(negedge clk);
    tx_en = 0; master_sel = 0; mclk_en = 1; sck_pad = 0; ws_pad = 0;
    repeat (4) @(negedge clk);
    check(sck_oe == 0 && ws_oe == 0, "R2", "slave enables", {sck_oe, ws_oe}, 0);
    tx_en = 1;
    n_r = 0; n_f = 0; n_fr = 0; first_r = -1; cyc = 0; bad_pad = 0;
    for (int b = 0; b < 16; b++) begin
      ws_pad = ((b % 4) < 2);
      for (int k = 0; k < 8; k++) begin
        if (k == 4) sck_pad = 1;
        @(negedge clk);
        cyc++;
        if (rise) begin n_r++; if (first_r < 0) first_r = cyc; end
        if (fall) n_f++;
        if (frame) n_fr++;
        if (sck || ws || sck_oe) bad_pad = 1;
      end
      sck_pad = 0;
    end
    repeat (6) begin
      @(negedge clk);
      if (rise) n_r++;
      if (fall) n_f++;
      if (frame) n_fr++;
    end
    check(n_r == 16, "R9", "slave rise count", n_r, 16);
    check(n_f == 16, "R9", "slave fall count", n_f, 16);
    check(!bad_pad, "R9", "slave pads quiet", bad_pad, 0);
    // pad rises before the 5th negedge of bit 0; visible 3 edges later
    check(first_r == 7, "R9", "slave rise latency", first_r, 7);
    check(n_fr == 4, "R10", "slave frame count", n_fr, 4);
    // role lock
    master_sel = 1;
    repeat (3) @(negedge clk);
    check(sck_oe == 0, "R2", "role held while enabled", sck_oe, 0);
    tx_en = 0;
    @(negedge clk);
    check(sck_oe == 1 && ws_oe == 1, "R2", "role taken while disabled", {sck_oe, ws_oe}, 3);
    mclk_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(outs() == 0 && sck_oe == 0 && ws_oe == 0, "R1", "reset state",
          {outs(), sck_oe, ws_oe}, 0);

    // R3 R4 R5: sweep of small ratios and frame lengths
    for (int n = 1; n <= 10; n++)
      for (int f = 1; f <= 6; f++)
        run_master(n, f, 1, 2 * n * f + 3, -1, n, f, "R3/R4/R5");
    run_master(256, 2, 1, 2 * 512 + 3, -1, 256, 2, "R3");
    run_master(2, 512, 1, 2 * 1024 + 3, -1, 2, 512, "R4");
    // R6: sparse ticks
    run_master(3, 4, 3, 30, -1, 3, 4, "R6");
    run_master(5, 3, 4, 35, -1, 5, 3, "R6");
    // R7: divider change mid-frame and right before a boundary
    run_master(4, 3, 1, 60, 5, 2, 5, "R7");
    run_master(5, 2, 1, 50, 9, 3, 3, "R7");
    run_master(5, 2, 1, 50, 11, 6, 1, "R7");
    run_master(3, 2, 2, 40, 2, 7, 2, "R7");

    run_slave();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule